// File: doc/BRIEF.md
# Flag-Conditioned Program Counter

This unit holds the address of the instruction being executed and chooses the next one. Each instruction takes one address, and instructions sit at consecutive addresses. On every clock edge the counter either moves to the next address or, when a conditional branch is requested and its condition is met, loads a supplied target address.

A branch condition tests exactly one of the four ALU status flags: overflow, carry, negative or zero. Each flag can be tested as set or as clear, which gives eight conditions. A 3-bit condition code selects the condition. Comparisons that need more than one flag, such as greater-than, are built in software from a suitable ALU operation and these single-flag tests.

The taken indication is purely combinational from the current inputs, so surrounding control logic can act on it in the same cycle. The counter register changes on the following rising edge. All pins are plain control and status signals. No stream data crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `br_pc_unit`

## Requirements
- R1: Reset is synchronous and active high. One rising edge with `rst` high sets `pc_o` to 0, whatever the branch inputs are.
- R2: After an edge where no branch is taken and reset is low, `pc_o` equals its previous value plus one.
- R3: Counting past 16'hFFFF wraps `pc_o` to 16'h0000.
- R4: Code 3'b000 takes the branch when `ovf_i` is 1. Code 3'b001 takes it when `ovf_i` is 0.
- R5: Code 3'b010 takes the branch when `carry_i` is 1. Code 3'b011 takes it when `carry_i` is 0.
- R6: Code 3'b100 takes the branch when `neg_i` is 1. Code 3'b101 takes it when `neg_i` is 0.
- R7: Code 3'b110 takes the branch when `zero_i` is 1. Code 3'b111 takes it when `zero_i` is 0.
- R8: `taken_o` is high in the same cycle that `br_en_i` is high and the selected condition holds. At the next rising edge `pc_o` becomes `target_i`.
- R9: While `br_en_i` is low, `taken_o` stays 0 and `pc_o` advances by one, whatever `cond_i` and the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_en_i | input | 1 | Current instruction is a conditional branch |
| cond_i | input | 3 | Condition code selecting the flag and its polarity |
| ovf_i | input | 1 | ALU overflow flag |
| carry_i | input | 1 | ALU carry flag |
| neg_i | input | 1 | ALU negative flag |
| zero_i | input | 1 | ALU zero flag |
| target_i | input | 16 | Branch destination address |
| pc_o | output | 16 | Current instruction address |
| taken_o | output | 1 | Branch taken this cycle |

## Verification
Every condition code is driven against its own flag both set and clear, with the other three flags set to the opposite value. This shows that the right flag is selected and that its polarity is not inverted. Branches with enable low are driven with codes and flags that would otherwise be taken, which separates gating by the enable from condition evaluation. A jump to the top address followed by a plain step checks the wrap. A taken branch asserted during reset checks that reset has priority.

// File: rtl/br_pc_pkg.sv
package br_pc_pkg;
  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CC_OVF_SET   = 3'b000,
    CC_OVF_CLR   = 3'b001,
    CC_CARRY_SET = 3'b010,
    CC_CARRY_CLR = 3'b011,
    CC_NEG_SET   = 3'b100,
    CC_NEG_CLR   = 3'b101,
    CC_ZERO_SET  = 3'b110,
    CC_ZERO_CLR  = 3'b111
  } cond_t;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } flags_t;
endpackage

// File: rtl/flag_cond_eval.sv
module flag_cond_eval
  import br_pc_pkg::*;
(
  input  cond_t  cond_i,
  input  flags_t flags_i,
  output logic   hit_o
);
  localparam int NFLAG = 4;

  // Upper code bits pick the flag, bit 0 selects the "clear" polarity.
  logic [NFLAG-1:0] flag_vec;
  logic             sel_flag;

  assign flag_vec = {flags_i.zero, flags_i.neg, flags_i.carry, flags_i.ovf};
  assign sel_flag = flag_vec[cond_i[COND_W-1:1]];
  assign hit_o    = sel_flag ^ cond_i[0];
endmodule

// File: rtl/pc_seq_reg.sv
module pc_seq_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] PC_RST = '0;
  localparam logic [PC_W-1:0] PC_INC = PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         pc_o <= PC_RST;
    else if (load_i) pc_o <= target_i;
    else             pc_o <= pc_o + PC_INC;
  end

  // R1: reset clears the counter
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc_o == PC_RST);

  // R2 / R3: sequential step with wrap
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> pc_o == PC_W'($past(pc_o) + PC_INC));

  // R8: loaded target appears after the edge
  p_load_target_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |=> pc_o == $past(target_i));
endmodule

// File: rtl/br_pc_unit.sv
module br_pc_unit
  import br_pc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_en_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              ovf_i,
  input  logic              carry_i,
  input  logic              neg_i,
  input  logic              zero_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              taken_o
);
  flags_t flags;
  logic   cond_hit;

  assign flags = '{ovf: ovf_i, carry: carry_i, neg: neg_i, zero: zero_i};

  flag_cond_eval u_eval (
    .cond_i (cond_t'(cond_i)),
    .flags_i(flags),
    .hit_o  (cond_hit)
  );

  assign taken_o = br_en_i & cond_hit;

  pc_seq_reg #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .load_i  (taken_o),
    .target_i(target_i),
    .pc_o    (pc_o)
  );

  // R9: no branch without enable
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !br_en_i |-> !taken_o);

  // R4: overflow codes
  p_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (taken_o && cond_i[2:1] == 2'b00) |-> ovf_i == !cond_i[0]);

  // R5: carry codes
  p_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (taken_o && cond_i[2:1] == 2'b01) |-> carry_i == !cond_i[0]);

  // R6: negative codes
  p_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (taken_o && cond_i[2:1] == 2'b10) |-> neg_i == !cond_i[0]);

  // R7: zero codes
  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (taken_o && cond_i[2:1] == 2'b11) |-> zero_i == !cond_i[0]);
endmodule

// File: tb/br_pc_unit_bench.sv
module br_pc_unit_bench;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            br_en = 1'b0;
  logic [2:0]      cond = 3'b000;
  logic            ovf = 1'b0, carry = 1'b0, neg = 1'b0, zero = 1'b0;
  logic [PC_W-1:0] target = '0;
  logic [PC_W-1:0] pc;
  logic            taken;

  int n_checks = 0;
  int n_fail   = 0;
  logic [PC_W-1:0] mdl_pc = '0;

  logic [PC_W-1:0] q_pc[$];
  string           q_tag[$];

  always #5 clk = ~clk;

  br_pc_unit #(.PC_W(PC_W)) u_br_pc_unit (
    .clk(clk), .rst(rst), .br_en_i(br_en), .cond_i(cond),
    .ovf_i(ovf), .carry_i(carry), .neg_i(neg), .zero_i(zero),
    .target_i(target), .pc_o(pc), .taken_o(taken)
  );

  function automatic logic want_hit(input logic [2:0] c, input logic v,
                                    input logic cy, input logic n, input logic z);
    case (c)
      3'b000: return v;
      3'b001: return !v;
      3'b010: return cy;
      3'b011: return !cy;
      3'b100: return n;
      3'b101: return !n;
      3'b110: return z;
      default: return !z;
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // driver: applies one cycle of stimulus, checks taken, queues expected PC
  task automatic step(input logic r, input logic en, input logic [2:0] c,
                      input logic [3:0] f, input logic [PC_W-1:0] tgt,
                      input string tag);
    logic exp_taken;
    @(negedge clk);
    rst = r; br_en = en; cond = c;
    {ovf, carry, neg, zero} = f;
    target = tgt;
    #1;
    exp_taken = en && want_hit(c, f[3], f[2], f[1], f[0]);
    n_checks++;
    if (taken !== exp_taken) begin
      n_fail++;
      $display("FAIL %s taken: actual %b expected %b", tag, taken, exp_taken);
    end
    if (r) mdl_pc = '0;
    else if (exp_taken) mdl_pc = tgt;
    else mdl_pc = mdl_pc + 1'b1;
    q_pc.push_back(mdl_pc);
    q_tag.push_back(tag);
  endtask

  // monitor: compares PC after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_pc.size() > 0) begin
        logic [PC_W-1:0] e;
        string t;
        e = q_pc.pop_front();
        t = q_tag.pop_front();
        n_checks++;
        if (pc !== e) begin
          n_fail++;
          $display("FAIL %s pc: actual %h expected %h", t, pc, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset, then reset beats a taken branch
    step(1, 0, 3'b000, 4'b0000, 16'h0000, "R1");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R2");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R2");
    step(1, 1, 3'b000, 4'b1000, 16'h1234, "R1");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R2");

    // each code: condition true then false, other flags opposite
    for (int k = 0; k < 8; k++) begin
      logic [3:0] fon, foff;
      logic [2:0] c;
      string tg;
      c = 3'(k);
      // flag index in {ovf,carry,neg,zero}: code[2:1]=0 ovf ... 3 zero
      fon = 4'b1000 >> c[2:1];
      foff = ~fon;
      if (c[0]) begin
        logic [3:0] t; t = fon; fon = foff; foff = t;
      end
      case (c[2:1])
        2'd0: tg = "R4";
        2'd1: tg = "R5";
        2'd2: tg = "R6";
        default: tg = "R7";
      endcase
      step(0, 1, c, fon,  16'h0100 + 16'(k * 16), tg);
      step(0, 1, c, foff, 16'hBEEF, tg);
      step(0, 0, c, 4'b0000, 16'h0000, "R2");
    end

    // R8: back-to-back taken branches
    step(0, 1, 3'b110, 4'b0001, 16'h4000, "R8");
    step(0, 1, 3'b011, 4'b0000, 16'h5000, "R8");

    // R9: enable low with conditions that would be taken
    step(0, 0, 3'b000, 4'b1000, 16'h7777, "R9");
    step(0, 0, 3'b111, 4'b0000, 16'h7777, "R9");
    step(0, 0, 3'b100, 4'b1111, 16'h7777, "R9");

    // R3: wrap from all ones
    step(0, 1, 3'b001, 4'b0000, 16'hFFFE, "R8");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R3");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R3");
    step(0, 0, 3'b000, 4'b0000, 16'h0000, "R3");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule